// File: doc/BRIEF.md
# Instruction Fetch Program Counter Sequencer

This block holds the program counter of a small microcontroller and decides which program word is fetched next. Each instruction cycle takes four system clocks. A free-running phase counter marks these as four one-hot phases. The PC, the pipeline state and the interrupt enable change only at the clock edge that closes the fourth phase. Fetch overlaps with execute: while one instruction executes, the word at `fetch_addr` is being fetched.

The decoder reports what the executing instruction does, and the block samples these requests at the cycle boundary. They are: a jump or call with its target, a return with an address popped from an external stack, a write of the PC low byte, and a skip whose condition is true. An external interrupt request is also sampled at the boundary. Any change of flow discards the prefetched word. The following cycle is then a dummy cycle, marked by `ir_valid` low. Requests presented during a dummy cycle are ignored.

When an interrupt is accepted, the block vectors to the interrupt entry and clears its global enable. For one instruction cycle it asks for the address of the discarded word to be pushed on the stack.

Top module: `ifetch_pc_seq`

## Requirements
- R1: `phase` is one-hot and steps 0001, 0010, 0100, 1000 on successive clocks. `fetch_addr`, `ir_valid`, `gie` and `push_req` change only on the edge taken while `phase` is 1000.
- R2: While `rst_n` is low, the outputs are `fetch_addr` = 000H, `ir_valid` = 0, `gie` = 0, `push_req` = 0 and `phase` = 0001.
- R3: With no request taken, a boundary increments `fetch_addr` by one, wrapping from 3FFH to 000H. `ir_valid` is then 1.
- R4: A jump or call (`jmp_req`) in a valid cycle loads `jmp_addr` into `fetch_addr`, and the next cycle is a dummy cycle (`ir_valid` = 0).
- R5: A return (`ret_req`) in a valid cycle loads `ret_addr`, and the next cycle is a dummy cycle.
- R6: A low-byte write (`pcl_wr`) in a valid cycle replaces `fetch_addr[7:0]` with `pcl_data` and keeps `fetch_addr[9:8]`. The next cycle is a dummy cycle.
- R7: A true skip (`skip_req`) in a valid cycle increments `fetch_addr` by one and makes the next cycle a dummy cycle.
- R8: An interrupt is accepted only when `int_req`, `gie` and `ir_valid` are all 1 and `stack_full` is 0. On acceptance, `fetch_addr` becomes 004H, `gie` becomes 0 and the next cycle is a dummy cycle. For that whole cycle, `push_req` = 1 and `push_addr` holds the `fetch_addr` value from before the boundary.
- R9: When several requests are present, priority runs interrupt, then jump, then return, then low-byte write, then skip.
- R10: In a dummy cycle, every request and `gie_set` is ignored. The boundary then only increments `fetch_addr` and sets `ir_valid` to 1.
- R11: `gie_set` in a valid cycle without an accepted interrupt sets `gie` at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| jmp_req | input | 1 | executing jump or call |
| jmp_addr | input | 10 | jump or call target |
| ret_req | input | 1 | executing return |
| ret_addr | input | 10 | address popped from the stack |
| pcl_wr | input | 1 | write of the PC low byte |
| pcl_data | input | 8 | value written to the low byte |
| skip_req | input | 1 | skip condition true |
| int_req | input | 1 | external interrupt request |
| gie_set | input | 1 | executing enable-interrupts |
| stack_full | input | 1 | stack has no free entry |
| fetch_addr | output | 10 | program memory fetch address |
| ir_valid | output | 1 | executing word is real (0 = dummy) |
| gie | output | 1 | global interrupt enable |
| push_req | output | 1 | push the interrupt return address |
| push_addr | output | 10 | return address to push |
| phase | output | 4 | one-hot instruction-cycle phase |

## Verification
The main stream is several hundred instruction cycles. In each cycle every request, the enable input and the stack-full flag are drawn from a pseudo-random sequence. The draws are sparse enough that runs of plain increments occur, but dense enough that multi-request collisions test the priority order. Requests that land in dummy cycles show whether they are correctly dropped. Directed sequences then cover the cases a random draw rarely reaches:
- the wrap from 3FFH;
- a low-byte write on a non-zero page, which tells a page-preserving write apart from a full load;
- an interrupt refused separately for stack full, enable clear and a dummy cycle, which shows that each blocking condition acts on its own.

The phase output and the stability of the PC in the middle of a cycle are checked on every cycle.

// File: rtl/ifetch_pc_seq.sv
module ifetch_pc_seq #(
  parameter int PC_W   = 10,
  parameter int PAGE_W = 8,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] INT_VEC = PC_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_req,
  input  logic [PC_W-1:0]   jmp_addr,
  input  logic              ret_req,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic              pcl_wr,
  input  logic [PAGE_W-1:0] pcl_data,
  input  logic              skip_req,
  input  logic              int_req,
  input  logic              gie_set,
  input  logic              stack_full,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              ir_valid,
  output logic              gie,
  output logic              push_req,
  output logic [PC_W-1:0]   push_addr,
  output logic [3:0]        phase
);

  logic [1:0]      ph;
  logic [PC_W-1:0] pc_q, pc_nxt, pc_inc;
  logic            vld_q, gie_q, push_q;
  logic [PC_W-1:0] push_addr_q;

  wire bnd      = (ph == 2'd3);
  wire take_int = vld_q & int_req & gie_q & ~stack_full;
  wire flush    = vld_q & (take_int | jmp_req | ret_req | pcl_wr | skip_req);

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    if (!vld_q)        pc_nxt = pc_inc;
    else if (take_int) pc_nxt = INT_VEC;
    else if (jmp_req)  pc_nxt = jmp_addr;
    else if (ret_req)  pc_nxt = ret_addr;
    else if (pcl_wr)   pc_nxt = {pc_q[PC_W-1:PAGE_W], pcl_data};
    else               pc_nxt = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= '0;
      pc_q        <= RST_VEC;
      vld_q       <= 1'b0;
      gie_q       <= 1'b0;
      push_q      <= 1'b0;
      push_addr_q <= '0;
    end else begin
      ph <= ph + 2'd1;
      if (bnd) begin
        pc_q   <= pc_nxt;
        vld_q  <= ~flush;
        push_q <= take_int;
        if (take_int) push_addr_q <= pc_q;
        if (take_int)              gie_q <= 1'b0;
        else if (vld_q && gie_set) gie_q <= 1'b1;
      end
    end
  end

  assign fetch_addr = pc_q;
  assign ir_valid   = vld_q;
  assign gie        = gie_q;
  assign push_req   = push_q;
  assign push_addr  = push_addr_q;
  assign phase      = 4'b0001 << ph;

  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);
  // R1
  pc_mid_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[3] |=> $stable(fetch_addr) && $stable(ir_valid) && $stable(gie));
  // R8
  int_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> (fetch_addr == INT_VEC) && !ir_valid && !gie);
  // R8
  stack_full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && stack_full) |=> !push_req);
  // R10
  dummy_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && !ir_valid) |=> ir_valid && !push_req);
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && ir_valid && !int_req && !jmp_req && !ret_req && !pcl_wr
     && !skip_req && fetch_addr == '1) |=> fetch_addr == '0 && ir_valid);

endmodule

// File: tb/ifetch_pc_seq_tb.sv
module ifetch_pc_seq_tb;
  logic clk = 0, rst_n = 0;
  logic jmp_req = 0, ret_req = 0, pcl_wr = 0, skip_req = 0, int_req = 0;
  logic gie_set = 0, stack_full = 0;
  logic [9:0] jmp_addr = 0, ret_addr = 0;
  logic [7:0] pcl_data = 0;
  logic [9:0] fetch_addr, push_addr;
  logic ir_valid, gie, push_req;
  logic [3:0] phase;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [9:0] m_pc = 0, m_push_addr = 0;
  logic m_vld = 0, m_gie = 0, m_push = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  ifetch_pc_seq u_dut (.clk, .rst_n, .jmp_req, .jmp_addr, .ret_req, .ret_addr,
    .pcl_wr, .pcl_data, .skip_req, .int_req, .gie_set, .stack_full,
    .fetch_addr, .ir_valid, .gie, .push_req, .push_addr, .phase);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic icycle(input string tag);
    logic [9:0] old_pc;
    logic take_int;
    string t;
    old_pc   = m_pc;
    take_int = m_vld && int_req && m_gie && !stack_full;
    t = tag;
    if (!m_vld) begin
      t = "R10"; m_pc = m_pc + 10'd1; m_vld = 1; m_push = 0;
    end else begin
      m_push = take_int;
      if (take_int) begin m_pc = 10'h004; m_push_addr = old_pc; t = "R8"; end
      else if (jmp_req) m_pc = jmp_addr;
      else if (ret_req) m_pc = ret_addr;
      else if (pcl_wr)  m_pc = {old_pc[9:8], pcl_data};
      else              m_pc = old_pc + 10'd1;
      m_vld = !(take_int || jmp_req || ret_req || pcl_wr || skip_req);
      if (take_int) m_gie = 0; else if (gie_set) m_gie = 1;
    end
    @(posedge clk); @(negedge clk);
    chk("R1 phase", phase, 4'b0010);
    chk("R1 stable", fetch_addr, old_pc);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({"R1 ", t}, phase, 4'b0001);
    chk({t, " pc"}, fetch_addr, m_pc);
    chk({t, " valid"}, ir_valid, m_vld);
    chk({t, " R11 gie"}, gie, m_gie);
    chk({t, " push"}, push_req, m_push);
    if (m_push) chk("R8 push_addr", push_addr, m_push_addr);
  endtask

  task automatic idle();
    jmp_req = 0; ret_req = 0; pcl_wr = 0; skip_req = 0; int_req = 0;
    gie_set = 0; stack_full = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 pc", fetch_addr, 10'h000);
    chk("R2 valid", ir_valid, 0);
    chk("R2 gie", gie, 0);
    chk("R2 push", push_req, 0);
    chk("R2 phase", phase, 4'b0001);
    rst_n = 1;
    icycle("R3");
    icycle("R3");
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = rnd(); b = rnd();
      jmp_req    = a[0] & a[1] & a[2];
      ret_req    = a[3] & a[4] & a[5];
      pcl_wr     = a[6] & a[7] & a[8];
      skip_req   = a[9] & a[10];
      int_req    = a[11] & a[12];
      gie_set    = a[13] & a[14];
      stack_full = a[15] & a[16];
      jmp_addr   = b[9:0];
      ret_addr   = b[19:10];
      pcl_data   = b[27:20];
      icycle("R9");
    end
    idle();
    jmp_addr = 10'h3FE; jmp_req = 1; icycle("R4");
    idle(); icycle("R10");
    icycle("R3");
    chk("R3 wrap", fetch_addr, 10'h000);
    jmp_addr = 10'h2C0; jmp_req = 1; icycle("R4");
    idle(); icycle("R10");
    pcl_wr = 1; pcl_data = 8'h17; icycle("R6");
    chk("R6 page kept", fetch_addr, 10'h217);
    idle(); icycle("R10");
    ret_addr = 10'h155; ret_req = 1; icycle("R5");
    idle(); icycle("R10");
    skip_req = 1; icycle("R7");
    idle(); icycle("R10");
    gie_set = 1; icycle("R11");
    idle();
    int_req = 1; stack_full = 1; icycle("R8");
    chk("R8 blocked full", push_req, 0);
    stack_full = 0; jmp_req = 1; jmp_addr = 10'h0F0; icycle("R9");
    chk("R9 int over jmp", fetch_addr, 10'h004);
    idle(); int_req = 1; gie_set = 1; icycle("R10");
    chk("R10 gie_set ignored", gie, 0);
    icycle("R8");
    chk("R8 blocked gie", push_req, 0);
    idle(); gie_set = 1; icycle("R11");
    int_req = 1; skip_req = 1; icycle("R8");
    idle(); int_req = 1; icycle("R10");
    chk("R10 int ignored in dummy", push_req, 0);
    idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule